// File: doc/BRIEF.md
# EDO DRAM Device Behavioural Target

This block is a clocked, synthesizable stand-in for the control side of a 16-bit extended-data-out DRAM. It serves as the target that a memory controller talks to in simulation or on a prototype. The row and column strobes, the write strobe, the output enable, the multiplexed address and the data are all active-low where applicable. They are sampled on a fast system clock, and strobe edges are found by comparing each sample with the one before it. The block keeps a small word array that is indexed by the low bits of the latched row and column. The storage therefore aliases across the rest of the address space.

The model supports three kinds of access. A read drives each byte lane whose column strobe is low. Its output stays valid after the strobes rise (EDO hold) until OE or W releases it. An early write lowers W before a column strobe falls: the outputs stay off, and data is taken at that strobe edge. A delayed write, or read-modify-write, lowers W while a strobe is already low, and data is taken on that W edge. A one-cycle flag reports a delayed write made while the outputs were still driving with OE asserted.

The control is a five-state machine. Transitions out of every state go to IDLE whenever RAS is high.
- **IDLE** (row closed) goes to **ROWOPEN** on a RAS fall, latching the row.
- **ROWOPEN** goes to **READ** or **WRITE** on the first column-strobe fall, chosen by W. The column is latched at that point.
- **READ** goes to **WRITE** when W is low while a strobe is low, which is a delayed write. It goes to **HOLD** when both strobes are high.
- **WRITE** goes back to **ROWOPEN** when both strobes are high.
- **HOLD** (EDO output kept) goes to **READ** or **WRITE** on a new column-strobe fall.

Top module: `edo_dram_model`

## Requirements
- R1: The row is captured on the cycle RAS is first sampled low. Storage uses row bits [1:0] and column bits [2:0] (word index = {row[1:0], col[2:0]}), so rows differing only above bit 1 alias.
- R2: The column is captured only when a strobe falls while both strobes were high in the previous sample. A second strobe falling during the same access does not change the column.
- R3: Byte lane 0 (bits 7:0, dq_oe[0]) belongs to lcas_n and lane 1 (bits 15:8, dq_oe[1]) to ucas_n. In a read, a lane drives only while its strobe is low and oe_n is low.
- R4: After a read, when both strobes return high, dq_out and dq_oe keep their values. They are released as soon as oe_n is high or we_n is low. Once released, they stay off until the next column access.
- R5: If we_n is low when the first strobe falls (early write), dq_oe stays 0 for the whole access whatever oe_n is. dq_in is written for each lane whose strobe is low in that cycle, and for any lane whose strobe falls later while we_n is low.
- R6: If a strobe is low in a read and we_n goes low (delayed write), dq_in is written in that cycle into the lanes whose strobes are low, and the outputs turn off.
- R7: With we_n high, nothing is written, whatever dq_in holds.
- R8: err_oe_conflict pulses high for one cycle after a delayed write taken while dq_oe was non-zero and oe_n was low. It is 0 otherwise.
- R9: RAS high closes the row: dq_oe is 0 from the next cycle on, and strobes or W activity while RAS is high write nothing.
- R10: Outputs are registered. They reflect the inputs sampled at the preceding clock edge, one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Column strobe for lane 0, active low |
| ucas_n | input | 1 | Column strobe for lane 1, active low |
| we_n | input | 1 | Write strobe, low selects write |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 12 | Multiplexed row/column address |
| dq_in | input | 16 | Write data from the controller |
| dq_out | output | 16 | Read data |
| dq_oe | output | 2 | Per-lane output drive enable |
| err_oe_conflict | output | 1 | Delayed write while outputs were driving |

## Verification
The bench goes after the EDO hold window. A design that tristated on the strobe rise would drop dq_oe one cycle after the strobes go high. A design that ignored OE or W in that window would keep driving, or would drive again when OE returned low.

It also checks the column rule with staggered strobes. A model that relatched on the second strobe would return the word at the second address. Early and delayed writes are mixed on single lanes. A wrong data strobe would corrupt the neighbouring byte or capture data at the wrong edge. Random accesses with aliased row and column bits expose a wrong index split.

// File: rtl/edo_pkg.sv
package edo_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROWOPEN,
        ST_READ,
        ST_WRITE,
        ST_HOLD
    } edo_state_t;
endpackage

// File: rtl/edo_strobe_edges.sv
module edo_strobe_edges #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ras_n,
    input  logic [LANES-1:0] cas_n,
    output logic             ras_fall,
    output logic [LANES-1:0] cas_fall,
    output logic             first_col
);
    logic             ras_q;
    logic [LANES-1:0] cas_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= '1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_n;
        end
    end

    assign ras_fall = ras_q & ~ras_n;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign cas_fall[i] = cas_q[i] & ~cas_n[i];
    end

    // a new column starts only when every strobe was high before
    assign first_col = (&cas_q) & ~(&cas_n);
endmodule

// File: rtl/edo_word_store.sv
module edo_word_store #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8,
    parameter int IDX_W  = 5
) (
    input  logic                    clk,
    input  logic [IDX_W-1:0]        rd_idx,
    output logic [LANES*LANE_W-1:0] rd_data,
    input  logic [LANES-1:0]        wr_en,
    input  logic [IDX_W-1:0]        wr_idx,
    input  logic [LANES*LANE_W-1:0] wr_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [LANES*LANE_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (wr_en[i])
                cells[wr_idx][i*LANE_W +: LANE_W] <= wr_data[i*LANE_W +: LANE_W];
        end
    end

    assign rd_data = cells[rd_idx];
endmodule

// File: rtl/edo_access_fsm.sv
module edo_access_fsm
    import edo_pkg::*;
#(
    parameter int LANES     = 2,
    parameter int LANE_W    = 8,
    parameter int ADDR_W    = 12,
    parameter int ROW_IDX_W = 2,
    parameter int COL_IDX_W = 3,
    localparam int DATA_W   = LANES * LANE_W,
    localparam int IDX_W    = ROW_IDX_W + COL_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic [LANES-1:0]  cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    input  logic              ras_fall,
    input  logic [LANES-1:0]  cas_fall,
    input  logic              first_col,
    input  logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  mem_idx,
    output logic [LANES-1:0]  wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] dq_out,
    output logic [LANES-1:0]  dq_oe,
    output logic              err_oe_conflict
);
    edo_state_t            state, state_nx;
    logic [ROW_IDX_W-1:0]  row_q;
    logic [COL_IDX_W-1:0]  col_q, col_sel;
    logic                  any_low, both_high, col_open;
    logic [LANES-1:0]      lane_drive;

    assign any_low    = ~(&cas_n);
    assign both_high  = &cas_n;
    assign col_open   = (state == ST_ROWOPEN || state == ST_HOLD) && first_col;
    assign col_sel    = col_open ? addr[COL_IDX_W-1:0] : col_q;
    assign mem_idx    = {row_q, col_sel};
    assign wr_data    = dq_in;
    assign lane_drive = ~cas_n & {LANES{~oe_n}};

    always_comb begin
        state_nx = state;
        if (ras_n) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    if (ras_fall) state_nx = ST_ROWOPEN;
                ST_ROWOPEN,
                ST_HOLD:    if (first_col) state_nx = we_n ? ST_READ : ST_WRITE;
                ST_READ: begin
                    if (!we_n && any_low) state_nx = ST_WRITE;
                    else if (both_high)   state_nx = ST_HOLD;
                end
                ST_WRITE:   if (both_high) state_nx = ST_ROWOPEN;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        wr_en = '0;
        if (!ras_n && !we_n) begin
            unique case (state)
                ST_ROWOPEN, ST_HOLD: if (first_col) wr_en = ~cas_n;
                ST_READ:             if (any_low) wr_en = ~cas_n;
                ST_WRITE:            wr_en = cas_fall;
                default:             wr_en = '0;
            endcase
        end
    end

    // state register with row/column latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            row_q <= '0;
            col_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && !ras_n && ras_fall)
                row_q <= addr[ROW_IDX_W-1:0];
            if (!ras_n && col_open)
                col_q <= addr[COL_IDX_W-1:0];
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dq_out          <= '0;
            dq_oe           <= '0;
            err_oe_conflict <= 1'b0;
        end else begin
            err_oe_conflict <= 1'b0;
            if (ras_n) begin
                dq_oe <= '0;
            end else begin
                unique case (state)
                    ST_ROWOPEN, ST_HOLD: begin
                        if (first_col) begin
                            dq_oe  <= we_n ? lane_drive : '0;
                            dq_out <= rd_data;
                        end else if (oe_n || !we_n) begin
                            dq_oe <= '0;
                        end
                    end
                    ST_READ: begin
                        if (!we_n && any_low) begin
                            err_oe_conflict <= (|dq_oe) & ~oe_n;
                            dq_oe <= '0;
                        end else if (both_high) begin
                            if (oe_n || !we_n) dq_oe <= '0;
                        end else begin
                            dq_oe  <= lane_drive;
                            dq_out <= rd_data;
                        end
                    end
                    default: dq_oe <= '0;
                endcase
            end
        end
    end

    a_r9_ras_release: assert property (@(posedge clk) disable iff (!rst_n)
        ras_n |=> (dq_oe == '0));
    a_r5_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE) |-> (dq_oe == '0));
    a_r3_lane_lo: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe[0]) |-> !$past(cas_n[0]));
    a_r3_lane_hi: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe[LANES-1]) |-> !$past(cas_n[LANES-1]));
    a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
        err_oe_conflict |-> (!$past(we_n) && !$past(oe_n)));
    a_r7_no_write_we_high: assert property (@(posedge clk) disable iff (!rst_n)
        we_n |-> (wr_en == '0));
endmodule

// File: rtl/edo_dram_model.sv
module edo_dram_model #(
    parameter int LANES     = 2,
    parameter int LANE_W    = 8,
    parameter int ADDR_W    = 12,
    parameter int ROW_IDX_W = 2,
    parameter int COL_IDX_W = 3,
    localparam int DATA_W   = LANES * LANE_W,
    localparam int IDX_W    = ROW_IDX_W + COL_IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              lcas_n,
    input  logic              ucas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic [LANES-1:0]  dq_oe,
    output logic              err_oe_conflict
);
    logic [LANES-1:0]  cas_n, cas_fall, wr_en;
    logic              ras_fall, first_col;
    logic [IDX_W-1:0]  mem_idx;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              unused_addr_hi;

    assign cas_n          = {ucas_n, lcas_n};
    assign unused_addr_hi = ^addr[ADDR_W-1:ROW_IDX_W];

    edo_strobe_edges #(.LANES(LANES)) u_edges (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .ras_fall(ras_fall), .cas_fall(cas_fall), .first_col(first_col)
    );

    edo_word_store #(.LANES(LANES), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rd_idx(mem_idx), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(mem_idx), .wr_data(wr_data)
    );

    edo_access_fsm #(
        .LANES(LANES), .LANE_W(LANE_W), .ADDR_W(ADDR_W),
        .ROW_IDX_W(ROW_IDX_W), .COL_IDX_W(COL_IDX_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
        .ras_fall(ras_fall), .cas_fall(cas_fall), .first_col(first_col),
        .rd_data(rd_data), .mem_idx(mem_idx), .wr_en(wr_en), .wr_data(wr_data),
        .dq_out(dq_out), .dq_oe(dq_oe), .err_oe_conflict(err_oe_conflict)
    );
endmodule

// File: tb/edo_dram_model_test.sv
module edo_dram_model_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [11:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out;
    logic [1:0]  dq_oe;
    logic        err_oe_conflict;

    int checks = 0;
    int failures = 0;
    logic [15:0] model [32];

    always #2.5 clk = ~clk;

    edo_dram_model uut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .err_oe_conflict(err_oe_conflict)
    );

    function automatic logic [15:0] bmask(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    function automatic int widx(input logic [11:0] row, input logic [11:0] col);
        return int'({row[1:0], col[2:0]});
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic l, input logic u, input logic w,
                        input logic o, input logic [11:0] a, input logic [15:0] d);
        ras_n = r; lcas_n = l; ucas_n = u; we_n = w; oe_n = o; addr = a; dq_in = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic model_write(input int i, input logic [1:0] m, input logic [15:0] d);
        model[i] = (model[i] & ~bmask(m)) | (d & bmask(m));
    endtask

    task automatic early_write(input logic [11:0] row, input logic [11:0] col,
                               input logic [1:0] m, input logic [15:0] d);
        step(0, 1, 1, 1, 0, row, 16'h0);
        step(0, ~m[0], ~m[1], 0, 0, col, d);
        chk("R5 early write outputs off", dq_oe, 2'b00);
        step(0, 1, 1, 0, 0, col, d);
        chk("R5 early write still off", dq_oe, 2'b00);
        step(1, 1, 1, 1, 1, 12'h0, 16'h0);
        model_write(widx(row, col), m, d);
    endtask

    task automatic read_access(input logic [11:0] row, input logic [11:0] col,
                               input logic [1:0] m);
        logic [15:0] exp;
        exp = model[widx(row, col)] & bmask(m);
        step(0, 1, 1, 1, 0, row, 16'h0);
        step(0, ~m[0], ~m[1], 1, 0, col, 16'hDEAD);
        chk("R3 R10 read lane enables", dq_oe, m);
        chk("R1 R3 read data", dq_out & bmask(m), exp);
        step(0, 1, 1, 1, 0, col, 16'h0);
        chk("R4 EDO hold enables", dq_oe, m);
        chk("R4 EDO hold data", dq_out & bmask(m), exp);
        step(1, 1, 1, 1, 0, 12'h0, 16'h0);
        chk("R9 RAS high releases", dq_oe, 2'b00);
    endtask

    task automatic delayed_write(input logic [11:0] row, input logic [11:0] col,
                                 input logic [1:0] m, input logic [15:0] d);
        step(0, 1, 1, 1, 1, row, 16'h0);
        step(0, ~m[0], ~m[1], 1, 1, col, 16'h0);
        step(0, ~m[0], ~m[1], 0, 1, col, d);
        chk("R6 delayed write outputs off", dq_oe, 2'b00);
        chk("R8 no conflict with OE high", err_oe_conflict, 1'b0);
        step(0, 1, 1, 1, 1, col, 16'h0);
        step(1, 1, 1, 1, 1, 12'h0, 16'h0);
        model_write(widx(row, col), m, d);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        for (int i = 0; i < 32; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset enables", dq_oe, 2'b00);
        chk("R8 reset flag", err_oe_conflict, 1'b0);

        // clear the array through the normal interface
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 8; c++)
                early_write(12'(r), 12'(c), 2'b11, 16'h0);

        // full word early write and read back
        early_write(12'h005, 12'h013, 2'b11, 16'hA5C3);
        read_access(12'h005, 12'h013, 2'b11);
        // R1 alias: row 0x001 / column 0x003 share the word
        read_access(12'h001, 12'h003, 2'b11);

        // R4 release on OE high, and sticky after OE returns low
        step(0, 1, 1, 1, 0, 12'h005, 16'h0);
        step(0, 0, 0, 1, 0, 12'h013, 16'h0);
        step(0, 1, 1, 1, 0, 12'h013, 16'h0);
        step(0, 1, 1, 1, 1, 12'h013, 16'h0);
        chk("R4 OE high releases hold", dq_oe, 2'b00);
        step(0, 1, 1, 1, 0, 12'h013, 16'h0);
        chk("R4 release stays after OE low", dq_oe, 2'b00);
        step(1, 1, 1, 1, 1, 12'h0, 16'h0);

        // R4 release on W low while strobes high
        step(0, 1, 1, 1, 0, 12'h005, 16'h0);
        step(0, 0, 1, 1, 0, 12'h013, 16'h0);
        step(0, 1, 1, 1, 0, 12'h013, 16'h0);
        chk("R4 hold lane 0 only", dq_oe, 2'b01);
        step(0, 1, 1, 0, 0, 12'h013, 16'h0);
        chk("R4 W low releases hold", dq_oe, 2'b00);
        step(1, 1, 1, 1, 1, 12'h0, 16'h0);

        // R3/R5 lane write: lane 0 only
        early_write(12'h005, 12'h013, 2'b01, 16'h1111);
        read_access(12'h005, 12'h013, 2'b10);
        read_access(12'h005, 12'h013, 2'b01);
        chk("R5 lane write merged", model[widx(12'h005, 12'h013)], 16'hA511);

        // R6 delayed write on lane 1
        delayed_write(12'h002, 12'h004, 2'b10, 16'h7E7E);
        read_access(12'h002, 12'h004, 2'b11);

        // R8 conflict: delayed write while driving with OE low
        step(0, 1, 1, 1, 0, 12'h003, 16'h0);
        step(0, 0, 0, 1, 0, 12'h006, 16'h0);
        chk("R8 driving before write", dq_oe, 2'b11);
        step(0, 0, 0, 0, 0, 12'h006, 16'hBEEF);
        chk("R8 conflict flag", err_oe_conflict, 1'b1);
        chk("R6 outputs off after delayed write", dq_oe, 2'b00);
        step(0, 0, 0, 0, 0, 12'h006, 16'hBEEF);
        chk("R8 flag single cycle", err_oe_conflict, 1'b0);
        step(0, 1, 1, 1, 0, 12'h006, 16'h0);
        step(1, 1, 1, 1, 1, 12'h0, 16'h0);
        model_write(widx(12'h003, 12'h006), 2'b11, 16'hBEEF);
        read_access(12'h003, 12'h006, 2'b11);

        // R2 staggered strobes: second strobe does not relatch column
        step(0, 1, 1, 1, 0, 12'h005, 16'h0);
        step(0, 0, 1, 1, 0, 12'h013, 16'h0);
        step(0, 0, 0, 1, 0, 12'h004, 16'h0);
        chk("R2 both lanes now driving", dq_oe, 2'b11);
        chk("R2 column kept from first strobe", dq_out, model[widx(12'h005, 12'h013)]);
        step(0, 1, 1, 1, 0, 12'h0, 16'h0);
        step(1, 1, 1, 1, 1, 12'h0, 16'h0);

        // R7 read cycle with junk on dq_in writes nothing
        step(0, 1, 1, 1, 0, 12'h002, 16'h0);
        step(0, 0, 0, 1, 0, 12'h004, 16'hFFFF);
        step(0, 0, 0, 1, 1, 12'h004, 16'hFFFF);
        step(0, 1, 1, 1, 1, 12'h004, 16'hFFFF);
        step(1, 1, 1, 1, 1, 12'h0, 16'h0);
        read_access(12'h002, 12'h004, 2'b11);

        // R9 strobes and W while RAS high write nothing
        step(1, 0, 0, 0, 0, 12'h013, 16'h0F0F);
        chk("R9 no drive with RAS high", dq_oe, 2'b00);
        step(1, 0, 0, 0, 0, 12'h013, 16'h0F0F);
        step(1, 1, 1, 1, 1, 12'h0, 16'h0);
        read_access(12'h005, 12'h013, 2'b11);
        read_access(12'h000, 12'h000, 2'b11);

        // constrained random mix
        for (int n = 0; n < 200; n++) begin
            logic [11:0] row, col;
            logic [1:0]  m;
            logic [15:0] d;
            int op;
            row = 12'($urandom);
            col = 12'($urandom) & 12'h3FF;
            m   = 2'(1 + ($urandom % 3));
            d   = 16'($urandom);
            op  = int'($urandom % 3);
            if (op == 0)      early_write(row, col, m, d);
            else if (op == 1) delayed_write(row, col, m, d);
            else              read_access(row, col, m);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule